// File: doc/BRIEF.md
# Coin Vending Controller

This block keeps a running sum of the coins a customer inserts and raises a one-cycle dispense pulse once that sum reaches the price of the item. Each coin arrives as a one-cycle strobe with an 8-bit value. The price is an 8-bit input that may change while the block runs. After a dispense the block clears its sum and waits for the next customer.

The block has two parts. The datapath holds an 8-bit running-total register with clear and load controls, a ripple adder and a less-than comparator. The controller is a four-phase state machine with the phases start, idle, accumulate and vend. The controller reads only the comparator's "total below price" flag and the coin strobe. It drives only the clear and load controls and the dispense pulse. All state changes on the rising clock edge, and reset is synchronous and active low.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller enters the start phase and `dispense` is 0 after that edge. Reset in the middle of a purchase discards the partial sum.
- R2: A coin strobe sampled in the idle phase causes exactly one addition of the coin value to the running total.
- R3: While the running total is below the price (unsigned 8-bit comparison), `dispense` stays 0.
- R4: When a coin brings the total to or above the price, `dispense` is 1 after the second rising edge following the edge that sampled the strobe. It is 1 for exactly one cycle.
- R5: After a dispense the sum is cleared to zero. The next purchase must pay the full price again.
- R6: A strobe sampled outside the idle phase (accumulate, start or vend) is ignored. A strobe held for two cycles adds the coin only once.
- R7: In the idle phase a coin strobe has priority over the dispense decision. The coin is added before the total is compared with the price.
- R8: The addition wraps modulo 256.
- R9: With a price of 0 and no coins, `dispense` pulses once every three cycles.
- R10: The coin value is taken in the accumulate cycle, which is the cycle after the strobe. The price is read afresh in every idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coin_strobe | input | 1 | One-cycle pulse per inserted coin |
| coin_value | input | 8 | Value of the current coin, valid in the cycle after the strobe |
| price | input | 8 | Item price, unsigned |
| dispense | output | 1 | One-cycle vend pulse |

## Verification
A coin strobe sampled at one edge updates the total at the next edge. The dispense decision is registered at the edge after that, so `dispense` is visible two edges after the strobe edge. With a price of zero the pulse repeats with a period of three cycles. A behavioural model in the bench advances at every rising edge from the same inputs. The design's output is compared with the model at every falling edge, so each comparison falls half a cycle after the edge that produced the result. Directed checks count falling edges from the strobe to confirm the exact cycle of the pulse, the coin-first priority, and pulse counts for the wrap, ignored-strobe and reset cases.

// File: rtl/coin_vend_pkg.sv
// Shared definitions for the coin vending controller.
// Assumes one data width serves coin values, price and running total.
package coin_vend_pkg;

    parameter int unsigned CV_DATA_W = 8;

    // Controller phases: start (clear), idle (wait), accumulate (add), vend.
    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_IDLE  = 2'd1,
        PH_ACCUM = 2'd2,
        PH_VEND  = 2'd3
    } cv_phase_t;

endpackage

// File: rtl/cv_ripple_add.sv
// Ripple-carry adder of parameterised width, result taken modulo 2**W.
// Assumes no carry in; the carry out is discarded on purpose (wrapping sum).
module cv_ripple_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum
);

    logic [W-1:0] carry;

    assign carry[0] = 1'b0;

    // One full-adder cell per bit; the last cell produces no carry.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = op_a[i] ^ op_b[i] ^ carry[i];
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = (op_a[i] & op_b[i]) | (carry[i] & (op_a[i] ^ op_b[i]));
        end
    end

endmodule

// File: rtl/cv_less_than.sv
// Unsigned less-than comparator built as a borrow chain of a - b.
// Assumes both operands are unsigned; lt is the final borrow.
module cv_less_than #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         lt
);

    logic [W:0] borrow;

    assign borrow[0] = 1'b0;

    // Borrow ripples from LSB to MSB.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign borrow[i+1] = (~op_a[i] & op_b[i]) | (~(op_a[i] ^ op_b[i]) & borrow[i]);
    end

    assign lt = borrow[W];

endmodule

// File: rtl/cv_tally_dp.sv
// Datapath: running-total register, adder and comparator against the price.
// Assumes the clear control wins over the load control when both are high.
module cv_tally_dp #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tot_clr,
    input  logic         tot_ld,
    input  logic [W-1:0] coin_value,
    input  logic [W-1:0] price,
    output logic         tot_lt_price,
    output logic [W-1:0] total
);

    logic [W-1:0] next_sum;

    cv_ripple_add #(.W(W)) u_add (
        .op_a (total),
        .op_b (coin_value),
        .sum  (next_sum)
    );

    cv_less_than #(.W(W)) u_cmp (
        .op_a (total),
        .op_b (price),
        .lt   (tot_lt_price)
    );

    // Running-total register: clear, load the sum, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || tot_clr) begin
            total <= '0;
        end else if (tot_ld) begin
            total <= next_sum;
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        tot_clr |=> (total == '0)); // R5

    AST_TOTAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tot_clr && !tot_ld) |=> $stable(total)); // R6

endmodule

// File: rtl/cv_ctrl_fsm.sv
// Controller: four-phase machine sequencing clear, wait, add and vend.
// Assumes one strobe cycle per coin; the dispense pulse is registered.
module cv_ctrl_fsm
    import coin_vend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic coin_strobe,
    input  logic tot_lt_price,
    output logic tot_clr,
    output logic tot_ld,
    output logic dispense
);

    cv_phase_t phase, phase_nxt;

    // Next-phase selection; a coin in idle beats the vend decision.
    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_START: phase_nxt = PH_IDLE;
            PH_IDLE: begin
                if (coin_strobe)       phase_nxt = PH_ACCUM;
                else if (!tot_lt_price) phase_nxt = PH_VEND;
                else                   phase_nxt = PH_IDLE;
            end
            PH_ACCUM: phase_nxt = PH_IDLE;
            PH_VEND:  phase_nxt = PH_START;
            default:  phase_nxt = PH_START;
        endcase
    end

    // Phase register with synchronous reset to start.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_START;
        else        phase <= phase_nxt;
    end

    // Registered dispense pulse, high during each vend phase.
    always_ff @(posedge clk) begin
        if (!rst_n) dispense <= 1'b0;
        else        dispense <= (phase_nxt == PH_VEND);
    end

    // Datapath controls decoded from the current phase.
    assign tot_clr = (phase == PH_START);
    assign tot_ld  = (phase == PH_ACCUM);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!dispense && phase == PH_START)); // R1

    AST_COIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && coin_strobe) |=> (phase == PH_ACCUM)); // R7

    AST_NO_EARLY_VEND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && tot_lt_price) |=> !dispense); // R3

    AST_ACCUM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACCUM) |=> (phase == PH_IDLE)); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dispense |=> !dispense); // R4

    AST_VEND_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        dispense |=> tot_clr); // R5

endmodule

// File: rtl/coin_vend_ctrl.sv
// Top: coin vending controller joining the tally datapath and controller.
// Assumes coin_value is valid in the cycle after its strobe.
module coin_vend_ctrl
    import coin_vend_pkg::*;
#(
    parameter int unsigned DATA_W = CV_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coin_strobe,
    input  logic [DATA_W-1:0] coin_value,
    input  logic [DATA_W-1:0] price,
    output logic              dispense
);

    logic              tot_clr;
    logic              tot_ld;
    logic              tot_lt_price;
    logic [DATA_W-1:0] total;

    cv_tally_dp #(.W(DATA_W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .tot_clr      (tot_clr),
        .tot_ld       (tot_ld),
        .coin_value   (coin_value),
        .price        (price),
        .tot_lt_price (tot_lt_price),
        .total        (total)
    );

    cv_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .coin_strobe  (coin_strobe),
        .tot_lt_price (tot_lt_price),
        .tot_clr      (tot_clr),
        .tot_ld       (tot_ld),
        .dispense     (dispense)
    );

    AST_VEND_NEEDS_PRICE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dispense) |-> !$past(tot_lt_price)); // R4

    AST_LOAD_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        tot_ld |=> (total == DATA_W'($past(total) + $past(coin_value)))); // R8

endmodule

// File: tb/coin_vend_ctrl_test.sv
module coin_vend_ctrl_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       coin_strobe;
    logic [7:0] coin_value;
    logic [7:0] price;
    logic       dispense;

    int checks = 0;
    int errors = 0;
    int dut_pulses = 0;
    string cur_req = "R1";
    bit started = 1'b0;

    // Behavioural reference: phase 0 start, 1 idle, 2 accumulate, 3 vend.
    int m_phase = 0;
    int m_tot = 0;
    bit m_disp = 1'b0;

    coin_vend_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .coin_strobe (coin_strobe),
        .coin_value  (coin_value),
        .price       (price),
        .dispense    (dispense)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model advance on each rising edge.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_phase = 0;
            m_tot   = 0;
        end else begin
            case (m_phase)
                0: begin m_tot = 0; m_phase = 1; end
                1: begin
                    if (coin_strobe)                m_phase = 2;
                    else if (m_tot >= int'(price))  m_phase = 3;
                end
                2: begin m_tot = (m_tot + int'(coin_value)) % 256; m_phase = 1; end
                default: m_phase = 0;
            endcase
        end
        m_disp = (m_phase == 3) && rst_n;
    end

    // Per-cycle comparison against the model and pulse counting.
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (dispense !== m_disp) begin
                errors++;
                $display("FAIL %s: cycle compare dispense=%b expected=%b", cur_req, dispense, m_disp);
            end
            if (rst_n && dispense === 1'b1) dut_pulses++;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dispense=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic expect_pulses(input string req, input int exp);
        checks++;
        if (dut_pulses != exp) begin
            errors++;
            $display("FAIL %s: pulses=%0d expected=%0d", req, dut_pulses, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", dispense, 1'b0);
        rst_n = 1'b1;
        dut_pulses = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Coin with its value held through the accumulate cycle.
    task automatic coin(input logic [7:0] v);
        @(negedge clk) begin coin_strobe = 1'b1; coin_value = v; end
        @(negedge clk) coin_strobe = 1'b0;
        @(negedge clk);
    endtask

    // Coin that should complete the price: pulse two edges after strobe edge.
    task automatic coin_timed(input logic [7:0] v, input string req);
        @(negedge clk) begin coin_strobe = 1'b1; coin_value = v; end
        @(negedge clk) coin_strobe = 1'b0;
        chk(req, dispense, 1'b0);
        @(negedge clk) chk(req, dispense, 1'b0);
        @(negedge clk) chk(req, dispense, 1'b1);
        @(negedge clk) chk(req, dispense, 1'b0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected end before %0d cycles", WD_CYCLES);
        summary();
    end

    initial begin
        rst_n = 1'b0; coin_strobe = 1'b0; coin_value = '0; price = 8'd50;

        // R1: reset state
        cur_req = "R1";
        do_reset();

        // R2 / R4: exact price reached by two coins
        cur_req = "R4";
        coin(8'd25);
        coin_timed(8'd25, "R4");
        idle(3);
        expect_pulses("R2", 1);

        // R5: after vend the total starts from zero again
        cur_req = "R5";
        dut_pulses = 0;
        coin(8'd25);
        idle(6);
        expect_pulses("R5", 0);

        // R3: below price, no dispense
        cur_req = "R3";
        price = 8'd100;
        do_reset();
        coin(8'd25); coin(8'd25); coin(8'd25);
        idle(8);
        expect_pulses("R3", 0);
        coin_timed(8'd25, "R3");

        // R8: wrap modulo 256
        cur_req = "R8";
        price = 8'd200;
        do_reset();
        coin(8'd150); coin(8'd150);
        idle(5);
        expect_pulses("R8", 0);
        coin_timed(8'd156, "R8");

        // R6: strobe held for two cycles adds once
        cur_req = "R6";
        price = 8'd50;
        do_reset();
        @(negedge clk) begin coin_strobe = 1'b1; coin_value = 8'd30; end
        @(negedge clk);
        @(negedge clk) coin_strobe = 1'b0;
        idle(4);
        expect_pulses("R6", 0);
        coin_timed(8'd20, "R6");
        // R6: strobe sampled in the start phase is ignored
        dut_pulses = 0;
        price = 8'd10;
        coin_strobe = 1'b1; coin_value = 8'd10;
        @(negedge clk) coin_strobe = 1'b0;
        idle(6);
        expect_pulses("R6", 0);

        // R7: coin beats vend decision after price drops
        cur_req = "R7";
        price = 8'd100;
        do_reset();
        coin(8'd40);
        idle(2);
        @(negedge clk) begin price = 8'd30; coin_strobe = 1'b1; coin_value = 8'd10; end
        @(negedge clk) coin_strobe = 1'b0;
        chk("R7", dispense, 1'b0);
        @(negedge clk) chk("R7", dispense, 1'b0);
        @(negedge clk) chk("R7", dispense, 1'b1);
        idle(2);
        expect_pulses("R7", 1);

        // R10: coin value taken in the accumulate cycle
        cur_req = "R10";
        price = 8'd60;
        do_reset();
        @(negedge clk) begin coin_strobe = 1'b1; coin_value = 8'd7; end
        @(negedge clk) begin coin_strobe = 1'b0; coin_value = 8'd60; end
        @(negedge clk) coin_value = 8'd0;
        idle(4);
        expect_pulses("R10", 1);

        // R9: zero price vends every third cycle
        cur_req = "R9";
        price = 8'd0;
        do_reset();
        for (int i = 0; i < 10 && dispense !== 1'b1; i++) @(negedge clk);
        chk("R9", dispense, 1'b1);
        @(negedge clk) chk("R9", dispense, 1'b0);
        @(negedge clk) chk("R9", dispense, 1'b0);
        @(negedge clk) chk("R9", dispense, 1'b1);

        // R1: reset mid-purchase discards the partial sum
        cur_req = "R1";
        price = 8'd50;
        do_reset();
        coin(8'd25);
        do_reset();
        coin(8'd25);
        idle(6);
        expect_pulses("R1", 0);

        summary();
    end

endmodule